// File: doc/BRIEF.md
# Two-Core Snooping Coherence Controller

This block keeps the private copies of two cores coherent. Each core owns one cache line. The line holds a valid bit, a shared bit, a dirty bit, a stored address (the tag) and one data word. Both cores send read and write requests through a valid/ready handshake. The controller serves one request at a time. It announces its coherence actions on a snooping bus output: invalidate, update, read request and data supply. It reaches main memory through a simple request/acknowledge port.

A single mode input picks the write policy.

- In invalidate mode, a write removes the peer's copy and keeps all further writes local.
- In update mode, every write also pushes the new word into the peer's copy.

Writes land only in the cache. When a core misses on a line its peer holds dirty, the peer supplies the word directly and memory is not read. A dirty line that must make room for another address is written back to memory first.

Top module: `coh_pair_ctrl`

## Requirements
- R1: Reset clears the valid, shared and dirty bits of both lines and leaves every output idle: `req_ready` = 0, `bus_op` = 0, `mem_req` = 0. The first read by either core after reset is a miss (`rsp_hit` = 0).
- R2: A request hits only when its core's line is valid and the stored tag equals the request address. A read hit returns the line's word with no bus operation and no memory access.
- R3: A miss places exactly one read request (`bus_op` code 3) on the bus, with `bus_addr` equal to the missed address.
- R4: If the peer holds the missed address dirty, the peer supplies its word (`bus_op` code 4, word on `bus_data`) and memory is not read. The requester's line becomes valid, shared and dirty. The peer becomes shared and stays dirty.
- R5: If no dirty copy exists, the miss is filled from the memory port. The requester's line becomes valid and clean, so a later replacement of it causes no memory write.
- R6: A write changes only the cache and sets the writer's dirty bit. No memory write happens on a write hit.
- R7: In invalidate mode (`mode_update` = 0), a write by a core whose shared bit is set emits one invalidate (`bus_op` code 1). The write clears the peer's valid bit when the peer holds the address, and clears the writer's shared bit. The peer's next read of that address misses.
- R8: In invalidate mode, consecutive writes by the same core emit only one invalidate. The peer's later miss receives the last written word.
- R9: In update mode (`mode_update` = 1), a write while the peer holds the address emits one update (`bus_op` code 2) carrying the new word. The new word is written into the peer's line and the writer's shared bit is set, so the peer's next read hits with the new word.
- R10: A miss on a line that is valid and dirty for another address first writes that word back to memory at its stored address. The memory request is held until acknowledged.
- R11: Only one request is in service at a time. When both cores request, core 0 is served first. `req_ready` is a one-cycle pulse for exactly one core.
- R12: Every read returns the most recently written word for its address, whichever core wrote it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_update | input | 1 | 0 = invalidate policy, 1 = update policy |
| req_valid | input | 2 | Request valid, one bit per core |
| req_write | input | 2 | 1 = write, 0 = read, per core |
| req_addr | input | 2*AW | Request address, core n in slice n |
| req_wdata | input | 2*DW | Write word, core n in slice n |
| req_ready | output | 2 | One-cycle completion pulse per core |
| rsp_rdata | output | DW | Read word, valid with `req_ready` |
| rsp_hit | output | 1 | Request hit on its first lookup, valid with `req_ready` |
| bus_op | output | 3 | Bus operation: 0 none, 1 invalidate, 2 update, 3 read request, 4 supply |
| bus_addr | output | AW | Address of the bus operation |
| bus_data | output | DW | Word carried by an update or supply |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Write-back word |
| mem_rdata | input | DW | Memory read word, valid with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
The bench targets the cases a wrong design would get wrong:

- **Burst of writes in invalidate mode.** A design that ignores the writer's shared bit sends an invalidate per write. One that forgets to clear the peer lets the peer hit on a stale word.
- **Miss on a line the peer holds dirty.** A design that reads memory here returns an old word. One that fails to mark the peer shared skips the invalidate on the next write.
- **Update-mode write followed by a peer read.** Without the push, the peer misses or reads stale data.
- **Eviction of a dirty line.** A missing write-back leaves memory stale.
- **Simultaneous requests and random mixes of both policies.** These expose arbitration order and coherence slips.

// File: rtl/coh_pkg.sv
package coh_pkg;
  localparam int NCORE = 2;

  typedef enum logic [2:0] {
    BUS_IDLE   = 3'd0,
    BUS_INV    = 3'd1,
    BUS_UPD    = 3'd2,
    BUS_RDREQ  = 3'd3,
    BUS_SUPPLY = 3'd4
  } bus_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WBACK,
    ST_FILL,
    ST_SUPPLY,
    ST_DONE
  } ctl_state_e;
endpackage

// File: rtl/coh_line_reg.sv
module coh_line_reg #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_v,
  input  logic          wr_s,
  input  logic          wr_d,
  input  logic [AW-1:0] wr_tag,
  input  logic [DW-1:0] wr_data,
  output logic          o_v,
  output logic          o_s,
  output logic          o_d,
  output logic [AW-1:0] o_tag,
  output logic [DW-1:0] o_data
);
  // State bits carry reset; tag and word are plain storage.
  always_ff @(posedge clk) begin
    if (rst) begin
      o_v <= 1'b0;
      o_s <= 1'b0;
      o_d <= 1'b0;
    end else if (wr_en) begin
      o_v <= wr_v;
      o_s <= wr_s;
      o_d <= wr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      o_tag  <= wr_tag;
      o_data <= wr_data;
    end
  end

  // R1: the cycle after reset, the line holds no state bits
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!o_v && !o_s && !o_d));
endmodule

// File: rtl/coh_arb.sv
module coh_arb import coh_pkg::*; (
  input  logic [NCORE-1:0] req_valid,
  output logic             gnt_any,
  output logic             gnt_idx
);
  // Fixed priority: core 0 wins a tie.
  always_comb begin
    gnt_any = |req_valid;
    gnt_idx = !req_valid[0];
  end
endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl import coh_pkg::*; #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_update,
  input  logic [NCORE-1:0]    req_write,
  input  logic [NCORE*AW-1:0] req_addr,
  input  logic [NCORE*DW-1:0] req_wdata,
  input  logic                gnt_any,
  input  logic                gnt_idx,
  input  logic [NCORE-1:0]    ln_v,
  input  logic [NCORE-1:0]    ln_s,
  input  logic [NCORE-1:0]    ln_d,
  input  logic [AW-1:0]       ln_tag  [NCORE],
  input  logic [DW-1:0]       ln_data [NCORE],
  output logic [NCORE-1:0]    lw_en,
  output logic [NCORE-1:0]    lw_v,
  output logic [NCORE-1:0]    lw_s,
  output logic [NCORE-1:0]    lw_d,
  output logic [AW-1:0]       lw_tag  [NCORE],
  output logic [DW-1:0]       lw_data [NCORE],
  output logic [NCORE-1:0]    req_ready,
  output logic [DW-1:0]       rsp_rdata,
  output logic                rsp_hit,
  output logic [2:0]          bus_op,
  output logic [AW-1:0]       bus_addr,
  output logic [DW-1:0]       bus_data,
  output logic                mem_req,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [DW-1:0]       mem_wdata,
  input  logic [DW-1:0]       mem_rdata,
  input  logic                mem_ack
);
  ctl_state_e       st_q, st_n;
  logic             cur_q, cur_n, wr_q, wr_n;
  logic [AW-1:0]    addr_q, addr_n;
  logic [DW-1:0]    wdata_q, wdata_n;
  bus_op_e          op_q, op_n;
  logic [AW-1:0]    baddr_q, baddr_n, maddr_q, maddr_n;
  logic [DW-1:0]    bdata_q, bdata_n, mwdata_q, mwdata_n, rdata_q, rdata_n;
  logic [NCORE-1:0] rdy_q, rdy_n;
  logic             hit_q, hit_n, mreq_q, mreq_n, mwe_q, mwe_n;
  logic             pr, own_hit, peer_has;

  assign pr       = ~cur_q;
  assign own_hit  = ln_v[cur_q] && (ln_tag[cur_q] == addr_q);
  assign peer_has = ln_v[pr] && (ln_tag[pr] == addr_q);

  always_comb begin
    st_n = st_q;  cur_n = cur_q;  wr_n = wr_q;  addr_n = addr_q;  wdata_n = wdata_q;
    op_n = BUS_IDLE;  baddr_n = baddr_q;  bdata_n = bdata_q;
    maddr_n = maddr_q;  mwdata_n = mwdata_q;  mreq_n = 1'b0;  mwe_n = mwe_q;
    rdata_n = rdata_q;  hit_n = hit_q;  rdy_n = '0;
    for (int k = 0; k < NCORE; k++) begin
      lw_en[k] = 1'b0;  lw_v[k] = ln_v[k];  lw_s[k] = ln_s[k];  lw_d[k] = ln_d[k];
      lw_tag[k] = ln_tag[k];  lw_data[k] = ln_data[k];
    end
    unique case (st_q)
      ST_IDLE: if (gnt_any) begin
        cur_n   = gnt_idx;
        wr_n    = req_write[gnt_idx];
        addr_n  = req_addr[int'(gnt_idx)*AW +: AW];
        wdata_n = req_wdata[int'(gnt_idx)*DW +: DW];
        hit_n   = 1'b1;
        st_n    = ST_LOOK;
      end
      ST_LOOK: begin
        if (own_hit) begin
          if (!wr_q) begin
            rdata_n = ln_data[cur_q];
          end else begin
            lw_en[cur_q] = 1'b1;  lw_data[cur_q] = wdata_q;  lw_d[cur_q] = 1'b1;
            if (!mode_update) begin
              if (ln_s[cur_q]) begin
                op_n = BUS_INV;  baddr_n = addr_q;
                if (peer_has) begin lw_en[pr] = 1'b1;  lw_v[pr] = 1'b0; end
              end
              lw_s[cur_q] = 1'b0;
            end else begin
              lw_s[cur_q] = peer_has;
              if (peer_has) begin
                op_n = BUS_UPD;  baddr_n = addr_q;  bdata_n = wdata_q;
                lw_en[pr] = 1'b1;  lw_data[pr] = wdata_q;
              end
            end
          end
          rdy_n[cur_q] = 1'b1;
          st_n = ST_DONE;
        end else begin
          hit_n = 1'b0;
          if (ln_v[cur_q] && ln_d[cur_q]) begin
            mreq_n = 1'b1;  mwe_n = 1'b1;
            maddr_n = ln_tag[cur_q];  mwdata_n = ln_data[cur_q];
            st_n = ST_WBACK;
          end else begin
            op_n = BUS_RDREQ;  baddr_n = addr_q;
            if (peer_has && ln_d[pr]) begin
              st_n = ST_SUPPLY;
            end else begin
              mreq_n = 1'b1;  mwe_n = 1'b0;  maddr_n = addr_q;
              st_n = ST_FILL;
            end
          end
        end
      end
      ST_WBACK: begin
        if (mem_ack) begin
          lw_en[cur_q] = 1'b1;  lw_v[cur_q] = 1'b0;  lw_s[cur_q] = 1'b0;  lw_d[cur_q] = 1'b0;
          st_n = ST_LOOK;
        end else mreq_n = 1'b1;
      end
      ST_FILL: begin
        if (mem_ack) begin
          lw_en[cur_q] = 1'b1;  lw_v[cur_q] = 1'b1;  lw_d[cur_q] = 1'b0;
          lw_s[cur_q] = peer_has;  lw_tag[cur_q] = addr_q;  lw_data[cur_q] = mem_rdata;
          if (peer_has) begin lw_en[pr] = 1'b1;  lw_s[pr] = 1'b1; end
          st_n = ST_LOOK;
        end else mreq_n = 1'b1;
      end
      ST_SUPPLY: begin
        op_n = BUS_SUPPLY;  baddr_n = addr_q;  bdata_n = ln_data[pr];
        lw_en[cur_q] = 1'b1;  lw_v[cur_q] = 1'b1;  lw_s[cur_q] = 1'b1;  lw_d[cur_q] = 1'b1;
        lw_tag[cur_q] = addr_q;  lw_data[cur_q] = ln_data[pr];
        lw_en[pr] = 1'b1;  lw_s[pr] = 1'b1;
        st_n = ST_LOOK;
      end
      ST_DONE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;  cur_q <= 1'b0;  wr_q <= 1'b0;  addr_q <= '0;  wdata_q <= '0;
      op_q <= BUS_IDLE;  baddr_q <= '0;  bdata_q <= '0;  maddr_q <= '0;  mwdata_q <= '0;
      mreq_q <= 1'b0;  mwe_q <= 1'b0;  rdata_q <= '0;  hit_q <= 1'b0;  rdy_q <= '0;
    end else begin
      st_q <= st_n;  cur_q <= cur_n;  wr_q <= wr_n;  addr_q <= addr_n;  wdata_q <= wdata_n;
      op_q <= op_n;  baddr_q <= baddr_n;  bdata_q <= bdata_n;  maddr_q <= maddr_n;
      mwdata_q <= mwdata_n;  mreq_q <= mreq_n;  mwe_q <= mwe_n;  rdata_q <= rdata_n;
      hit_q <= hit_n;  rdy_q <= rdy_n;
    end
  end

  assign req_ready = rdy_q;
  assign rsp_rdata = rdata_q;
  assign rsp_hit   = hit_q;
  assign bus_op    = op_q;
  assign bus_addr  = baddr_q;
  assign bus_data  = bdata_q;
  assign mem_req   = mreq_q;
  assign mem_we    = mwe_q;
  assign mem_addr  = maddr_q;
  assign mem_wdata = mwdata_q;

  p_ready_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rdy_q));
  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    (rdy_q != '0) |=> (rdy_q == '0));
  p_inv_clears_peer_r7: assert property (@(posedge clk) disable iff (rst)
    (op_q == BUS_INV) |-> !(ln_v[pr] && (ln_tag[pr] == baddr_q)));
  p_upd_copies_r9: assert property (@(posedge clk) disable iff (rst)
    (op_q == BUS_UPD) |-> (ln_data[pr] == bdata_q));
  p_supply_no_mem_r4: assert property (@(posedge clk) disable iff (rst)
    (op_q == BUS_SUPPLY) |-> !mreq_q);
  p_write_no_mem_r6: assert property (@(posedge clk) disable iff (rst)
    ((op_q == BUS_INV) || (op_q == BUS_UPD)) |-> !mreq_q);
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mreq_q && !mem_ack) |=> (mreq_q && $stable(maddr_q)));
endmodule

// File: rtl/coh_pair_ctrl.sv
module coh_pair_ctrl import coh_pkg::*; #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_update,
  input  logic [NCORE-1:0]    req_valid,
  input  logic [NCORE-1:0]    req_write,
  input  logic [NCORE*AW-1:0] req_addr,
  input  logic [NCORE*DW-1:0] req_wdata,
  output logic [NCORE-1:0]    req_ready,
  output logic [DW-1:0]       rsp_rdata,
  output logic                rsp_hit,
  output logic [2:0]          bus_op,
  output logic [AW-1:0]       bus_addr,
  output logic [DW-1:0]       bus_data,
  output logic                mem_req,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [DW-1:0]       mem_wdata,
  input  logic [DW-1:0]       mem_rdata,
  input  logic                mem_ack
);
  logic             gnt_any, gnt_idx;
  logic [NCORE-1:0] ln_v, ln_s, ln_d, lw_en, lw_v, lw_s, lw_d;
  logic [AW-1:0]    ln_tag [NCORE];
  logic [AW-1:0]    lw_tag [NCORE];
  logic [DW-1:0]    ln_data [NCORE];
  logic [DW-1:0]    lw_data [NCORE];

  coh_arb u_arb (.req_valid(req_valid), .gnt_any(gnt_any), .gnt_idx(gnt_idx));

  for (genvar g = 0; g < NCORE; g++) begin : g_line
    coh_line_reg #(.AW(AW), .DW(DW)) u_line (
      .clk(clk), .rst(rst), .wr_en(lw_en[g]), .wr_v(lw_v[g]), .wr_s(lw_s[g]),
      .wr_d(lw_d[g]), .wr_tag(lw_tag[g]), .wr_data(lw_data[g]),
      .o_v(ln_v[g]), .o_s(ln_s[g]), .o_d(ln_d[g]), .o_tag(ln_tag[g]), .o_data(ln_data[g]));
  end

  coh_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .mode_update(mode_update), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .gnt_any(gnt_any), .gnt_idx(gnt_idx),
    .ln_v(ln_v), .ln_s(ln_s), .ln_d(ln_d), .ln_tag(ln_tag), .ln_data(ln_data),
    .lw_en(lw_en), .lw_v(lw_v), .lw_s(lw_s), .lw_d(lw_d), .lw_tag(lw_tag), .lw_data(lw_data),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .rsp_hit(rsp_hit),
    .bus_op(bus_op), .bus_addr(bus_addr), .bus_data(bus_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack));
endmodule

// File: tb/tb_coh_pair_ctrl.sv
`timescale 1ns/1ps
module tb_coh_pair_ctrl;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst = 1'b1, mode_update = 1'b0;
  logic [1:0] req_valid = '0, req_write = '0, req_ready;
  logic [2*AW-1:0] req_addr = '0;
  logic [2*DW-1:0] req_wdata = '0;
  logic [DW-1:0] rsp_rdata, bus_data, mem_wdata, mem_rdata;
  logic rsp_hit, mem_req, mem_we, mem_ack;
  logic [2:0] bus_op;
  logic [AW-1:0] bus_addr, mem_addr;

  int n_run = 0, n_fail = 0;
  logic [DW-1:0] memory [DEPTH];
  logic [DW-1:0] golden [DEPTH];
  logic [DW-1:0] mmem [DEPTH];
  bit mv[2], ms[2], md[2];
  logic [AW-1:0] mtag[2];
  logic [DW-1:0] mdata[2];
  bit o_hit;
  logic [DW-1:0] o_rd;
  int o_inv, o_upd, o_rdq, o_sup, o_mw;

  always #2 clk = ~clk;

  coh_pair_ctrl #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .mode_update(mode_update), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .rsp_hit(rsp_hit),
    .bus_op(bus_op), .bus_addr(bus_addr), .bus_data(bus_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack));

  function automatic logic [DW-1:0] init_word(int i);
    return DW'(i * 7 + 3);
  endfunction

  // Memory responder: acknowledges one cycle after a request is seen
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
      for (int i = 0; i < DEPTH; i++) memory[i] <= init_word(i);
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_we) memory[mem_addr] <= mem_wdata;
        else mem_rdata <= memory[mem_addr];
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Transaction-level reference of the requirements
  task automatic model_step(input int c, input bit w, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input bit m, output bit hit,
                            output logic [DW-1:0] rd, output int ninv, output int nupd,
                            output int nrdq, output int nsup, output int nmw);
    int p = 1 - c;
    bit pm;
    ninv = 0; nupd = 0; nrdq = 0; nsup = 0; nmw = 0; rd = '0;
    hit = mv[c] && (mtag[c] == a);
    if (!hit) begin
      if (mv[c] && md[c]) begin
        mmem[mtag[c]] = mdata[c]; nmw++; mv[c] = 0; ms[c] = 0; md[c] = 0;
      end
      nrdq++;
      pm = mv[p] && (mtag[p] == a);
      if (pm && md[p]) begin
        nsup++; mdata[c] = mdata[p]; mv[c] = 1; ms[c] = 1; md[c] = 1; ms[p] = 1;
      end else begin
        mdata[c] = mmem[a]; mv[c] = 1; md[c] = 0; ms[c] = pm;
        if (pm) ms[p] = 1;
      end
      mtag[c] = a;
    end
    pm = mv[p] && (mtag[p] == a);
    if (!w) rd = mdata[c];
    else begin
      mdata[c] = d; md[c] = 1;
      if (!m) begin
        if (ms[c]) begin ninv++; if (pm) mv[p] = 0; end
        ms[c] = 0;
      end else begin
        if (pm) begin nupd++; mdata[p] = d; ms[c] = 1; end
        else ms[c] = 0;
      end
    end
  endtask

  task automatic do_req(input int c, input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    bit e_hit; logic [DW-1:0] e_rd; int e_inv, e_upd, e_rdq, e_sup, e_mw;
    int guard = 0;
    model_step(c, w, a, d, mode_update, e_hit, e_rd, e_inv, e_upd, e_rdq, e_sup, e_mw);
    o_inv = 0; o_upd = 0; o_rdq = 0; o_sup = 0; o_mw = 0;
    @(negedge clk);
    req_valid[c] = 1'b1; req_write[c] = w;
    req_addr[c*AW +: AW] = a; req_wdata[c*DW +: DW] = d;
    do begin
      @(negedge clk);
      guard++;
      case (bus_op)
        3'd1: o_inv++;
        3'd2: o_upd++;
        3'd3: begin o_rdq++; check(bus_addr == a, "R3 rdreq address", bus_addr, a); end
        3'd4: o_sup++;
        default: ;
      endcase
      if (mem_req && mem_we && mem_ack) o_mw++;
    end while (!req_ready[c] && guard < 60);
    check(req_ready[c], "R11 completion pulse", req_ready[c], 1);
    o_hit = rsp_hit; o_rd = rsp_rdata;
    @(posedge clk);
    @(negedge clk);
    req_valid[c] = 1'b0;
    check(o_hit == e_hit, "R2 hit flag", o_hit, e_hit);
    if (!w) check(o_rd == golden[a], "R12 read word", o_rd, golden[a]);
    else golden[a] = d;
    check(o_rdq == e_rdq, "R3 read request count", o_rdq, e_rdq);
    check(o_sup == e_sup, "R4 supply count", o_sup, e_sup);
    check(o_inv == e_inv, "R7 invalidate count", o_inv, e_inv);
    check(o_upd == e_upd, "R9 update count", o_upd, e_upd);
    check(o_mw == e_mw, "R10 memory write count", o_mw, e_mw);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit e_hit; logic [DW-1:0] e_rd0, e_rd1; int x0, x1, x2, x3, x4;
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) begin golden[i] = init_word(i); mmem[i] = init_word(i); end
    for (int k = 0; k < 2; k++) begin mv[k] = 0; ms[k] = 0; md[k] = 0; mtag[k] = '0; mdata[k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(req_ready == 2'b00, "R1 ready idle", req_ready, 0);
    check(bus_op == 3'd0, "R1 bus idle", bus_op, 0);
    check(mem_req == 1'b0, "R1 memory idle", mem_req, 0);

    // Invalidate mode
    mode_update = 1'b0;
    do_req(0, 0, 4'd5, '0);
    check(o_hit == 0, "R1 first read misses", o_hit, 0);
    check(o_sup == 0, "R5 clean miss from memory", o_sup, 0);
    do_req(1, 0, 4'd5, '0);
    do_req(0, 1, 4'd5, 8'h11);
    check(o_inv == 1, "R7 first write invalidates", o_inv, 1);
    check(o_mw == 0, "R6 write hit no memory write", o_mw, 0);
    do_req(0, 1, 4'd5, 8'h22);
    check(o_inv == 0, "R8 second write silent", o_inv, 0);
    do_req(0, 1, 4'd5, 8'h33);
    check(o_inv == 0, "R8 third write silent", o_inv, 0);
    do_req(1, 0, 4'd5, '0);
    check(o_hit == 0, "R7 peer misses", o_hit, 0);
    check(o_rd == 8'h33, "R8 latest word supplied", o_rd, 8'h33);
    check(o_sup == 1, "R4 dirty owner supplies", o_sup, 1);
    do_req(0, 1, 4'd5, 8'h3a);
    check(o_inv == 1, "R4 owner became shared", o_inv, 1);

    // Update mode
    mode_update = 1'b1;
    do_req(1, 0, 4'd5, '0);
    do_req(0, 1, 4'd5, 8'h44);
    check(o_upd == 1, "R9 update pushed", o_upd, 1);
    do_req(1, 0, 4'd5, '0);
    check(o_hit == 1, "R9 peer hits", o_hit, 1);
    check(o_rd == 8'h44, "R9 peer word", o_rd, 8'h44);

    // Replacement
    do_req(0, 0, 4'd9, '0);
    check(o_mw == 1, "R10 dirty write-back", o_mw, 1);
    check(memory[5] == 8'h44, "R10 memory holds written word", memory[5], 8'h44);
    do_req(0, 0, 4'd11, '0);
    check(o_mw == 0, "R5 clean line dropped", o_mw, 0);

    // Simultaneous requests
    mode_update = 1'b0;
    model_step(0, 0, 4'd2, '0, 1'b0, e_hit, e_rd0, x0, x1, x2, x3, x4);
    model_step(1, 0, 4'd3, '0, 1'b0, e_hit, e_rd1, x0, x1, x2, x3, x4);
    @(negedge clk);
    req_write = 2'b00; req_addr = {4'd3, 4'd2}; req_valid = 2'b11;
    for (int g = 0; g < 60 && req_ready == 2'b00; g++) @(negedge clk);
    check(req_ready == 2'b01, "R11 core 0 first", req_ready, 1);
    check(rsp_rdata == e_rd0, "R12 core 0 word", rsp_rdata, e_rd0);
    @(posedge clk); @(negedge clk); req_valid[0] = 1'b0;
    for (int g = 0; g < 60 && req_ready == 2'b00; g++) @(negedge clk);
    check(req_ready == 2'b10, "R11 core 1 second", req_ready, 2);
    check(rsp_rdata == e_rd1, "R12 core 1 word", rsp_rdata, e_rd1);
    @(posedge clk); @(negedge clk); req_valid[1] = 1'b0;

    // Random mix of both policies
    for (int t = 0; t < 400; t++) begin
      int c = int'($urandom_range(0, 1));
      bit w = bit'($urandom_range(0, 1));
      logic [AW-1:0] a = AW'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) a = a + AW'(8);
      mode_update = bit'($urandom_range(0, 1));
      do_req(c, w, a, DW'($urandom_range(0, 255)));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule